// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Wake Filter

This block receives asynchronous serial frames on a single input line and places each received byte in a data register. It raises a data-ready flag, a stop-bit error flag and an overrun flag, and drives two interrupt outputs that one enable bit gates together. The input is oversampled at 16 times the bit rate, using a tick from a plain clock divider. When the multiprocessor mode input is high, each frame carries one extra bit after the eight data bits. This bit marks the frame as an address (1) or as data (0).

A wake filter lets a station on a shared line ignore traffic meant for other stations. While the filter enable is set and multiprocessor mode is selected, frames whose extra bit is 0 are thrown away and no flag or data changes. The first frame whose extra bit is 1 clears the filter enable in hardware and is received as a normal frame, and so are all frames after it. Software loads the three control bits through a write strobe during setup and clears flags with one-cycle pulses. The control bits can always be read back on dedicated outputs.

Top module: `mpu_uart_rx`

## Requirements
- R1: A frame is a low start bit, DATA_W data bits sent LSB first, one extra bit only when `mp_mode_i` is 1, and a high stop bit. A valid frame loads `rx_data_o` and sets `rdf_o`.
- R2: Frames are received only while the receive enable is 1. Clearing it in the middle of a frame abandons that frame, and no flag is set.
- R3: A low stop bit sets `fer_o` and leaves `rdf_o` clear.
- R4: A frame that completes while `rdf_o` is 1 sets `ore_o` and leaves `rx_data_o` unchanged.
- R5: While the filter enable is 1 and `mp_mode_i` is 1, a frame whose extra bit is 0 changes no flag and no data, and the filter enable stays 1.
- R6: In that state, a frame whose extra bit is 1 clears the filter enable and is received normally, and so are the frames that follow it.
- R7: With `mp_mode_i` at 0 the filter enable has no effect: frames are received and the bit keeps its value.
- R8: `rxi_o` is `rdf_o` AND the interrupt enable. `eri_o` is (`fer_o` OR `ore_o`) AND the interrupt enable.
- R9: Reset clears all control bits and flags. `cfg_wr_i` loads the three control bits. A 1 on `flag_clr_i` bit 0, 1 or 2 clears `rdf_o`, `fer_o` or `ore_o` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idles high |
| mp_mode_i | input | 1 | Selects frames with the extra address/data bit |
| cfg_wr_i | input | 1 | Write strobe for the control bits |
| cfg_rx_en_i | input | 1 | Receive enable value to write |
| cfg_rie_i | input | 1 | Interrupt enable value to write |
| cfg_mpie_i | input | 1 | Filter enable value to write |
| flag_clr_i | input | 3 | Clear pulses: bit0 rdf, bit1 fer, bit2 ore |
| rx_en_o | output | 1 | Receive enable readback |
| rie_o | output | 1 | Interrupt enable readback |
| mpie_o | output | 1 | Filter enable readback |
| rx_data_o | output | DATA_W | Last accepted byte |
| rdf_o | output | 1 | Receive data full |
| fer_o | output | 1 | Framing error |
| ore_o | output | 1 | Overrun |
| rxi_o | output | 1 | Receive interrupt |
| eri_o | output | 1 | Receive-error interrupt |

## Verification
The hardest case to reach is a filtered frame that arrives while the data-full flag is already set. Only in that case can the filter show that it blocks an overrun, not just the data-full flag. The stimulus first takes a normal address-mode frame with the filter off so that the data-full flag sets. It then turns the filter on without clearing the flag and sends a data frame. After the flags are cleared, a data frame with a low stop bit is sent to show that the framing flag is blocked too. Last, an address frame wakes the receiver, and a data frame after it must be received normally.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  typedef struct packed {
    logic rx_en;
    logic rie;
    logic mpie;
  } ctrl_t;

  typedef struct packed {
    logic ore;
    logic fer;
    logic rdf;
  } flags_t;
endpackage

// File: rtl/mpu_tick_gen.sv
module mpu_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mpu_rx_shift.sv
module mpu_rx_shift
  import mpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic              mp_mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              stop_ok_o
);
  localparam int unsigned OCW  = $clog2(OVS);
  localparam int unsigned BW   = $clog2(DATA_W + 2);
  localparam int unsigned HALF = OVS/2 - 1;

  rx_state_e         state_q;
  logic [OCW-1:0]    os_q;
  logic [BW-1:0]     idx_q;
  logic [DATA_W-1:0] data_q;
  logic              mpb_q, stop_q, done_q;
  logic [1:0]        sync_q;
  logic              rxd_s;
  logic [BW-1:0]     last_idx;

  assign rxd_s    = sync_q[1];
  assign last_idx = BW'(DATA_W) + BW'(mp_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      mpb_q   <= 1'b0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!rxd_s) begin
            state_q <= RX_START;
            os_q    <= '0;
          end
          RX_START: begin
            if (os_q == OCW'(HALF)) begin
              // confirm start at mid-bit, else treat as glitch
              state_q <= rxd_s ? RX_IDLE : RX_BITS;
              os_q    <= '0;
              idx_q   <= '0;
              mpb_q   <= 1'b0;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          RX_BITS: begin
            os_q <= os_q + 1'b1;
            if (os_q == OCW'(OVS-1)) begin
              os_q  <= '0;
              idx_q <= idx_q + 1'b1;
              if (idx_q == last_idx) begin
                stop_q  <= rxd_s;
                done_q  <= 1'b1;
                state_q <= RX_IDLE;
              end else if (idx_q < BW'(DATA_W)) begin
                data_q <= {rxd_s, data_q[DATA_W-1:1]};
              end else begin
                mpb_q <= rxd_s;
              end
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o    = done_q;
  assign data_o    = data_q;
  assign mpb_o     = mpb_q;
  assign stop_ok_o = stop_q;

  a_r2_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE) && !done_q);

  a_r1_done_is_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/mpu_rx_ctrl.sv
module mpu_rx_ctrl
  import mpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  ctrl_t             cfg_i,
  input  logic [2:0]        flag_clr_i,
  input  logic              mp_mode_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  input  logic              stop_ok_i,
  output ctrl_t             ctrl_o,
  output flags_t            flags_o,
  output logic [DATA_W-1:0] rdr_o
);
  ctrl_t             ctrl_q, ctrl_d;
  flags_t            flags_q, flags_d;
  logic [DATA_W-1:0] rdr_q, rdr_d;
  logic              filt_on, drop, accept;

  assign filt_on = ctrl_q.mpie & mp_mode_i;
  assign drop    = done_i & filt_on & ~mpb_i;
  assign accept  = done_i & ~drop;

  always_comb begin
    ctrl_d = ctrl_q;
    if (accept && filt_on) ctrl_d.mpie = 1'b0;
    if (cfg_wr_i)          ctrl_d      = cfg_i;
  end

  always_comb begin
    flags_d = flags_q;
    rdr_d   = rdr_q;
    if (flag_clr_i[0]) flags_d.rdf = 1'b0;
    if (flag_clr_i[1]) flags_d.fer = 1'b0;
    if (flag_clr_i[2]) flags_d.ore = 1'b0;
    // set wins over a same-cycle clear
    if (accept) begin
      if (flags_q.rdf) begin
        flags_d.ore = 1'b1;
      end else begin
        rdr_d = data_i;
        if (stop_ok_i) flags_d.rdf = 1'b1;
        else           flags_d.fer = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      rdr_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
      rdr_q   <= rdr_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign flags_o = flags_q;
  assign rdr_o   = rdr_q;

  a_r5_drop_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop && !cfg_wr_i && (flag_clr_i == 3'b000)
    |=> $stable(flags_q) && $stable(rdr_q) && ctrl_q.mpie);

  a_r6_wake_clears_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && mpb_i && filt_on && !cfg_wr_i |=> !ctrl_q.mpie);

  a_r4_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && flags_q.rdf |=> flags_q.ore && $stable(rdr_q));

  a_r3_bad_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !flags_q.rdf && !stop_ok_i |=> flags_q.fer && !flags_q.rdf);
endmodule

// File: rtl/mpu_uart_rx.sv
module mpu_uart_rx
  import mpu_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              mp_mode_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_rx_en_i,
  input  logic              cfg_rie_i,
  input  logic              cfg_mpie_i,
  input  logic [2:0]        flag_clr_i,
  output logic              rx_en_o,
  output logic              rie_o,
  output logic              mpie_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rdf_o,
  output logic              fer_o,
  output logic              ore_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic              tick, done, mpb, stop_ok;
  logic [DATA_W-1:0] sh_data;
  ctrl_t             cfg_w, ctrl;
  flags_t            flags;

  assign cfg_w = '{rx_en: cfg_rx_en_i, rie: cfg_rie_i, mpie: cfg_mpie_i};

  mpu_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  mpu_rx_shift #(.DATA_W(DATA_W), .OVS(OVS)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rxd_i     (rxd_i),
    .en_i      (ctrl.rx_en),
    .mp_mode_i (mp_mode_i),
    .done_o    (done),
    .data_o    (sh_data),
    .mpb_o     (mpb),
    .stop_ok_o (stop_ok)
  );

  mpu_rx_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_i      (cfg_w),
    .flag_clr_i (flag_clr_i),
    .mp_mode_i  (mp_mode_i),
    .done_i     (done),
    .data_i     (sh_data),
    .mpb_i      (mpb),
    .stop_ok_i  (stop_ok),
    .ctrl_o     (ctrl),
    .flags_o    (flags),
    .rdr_o      (rx_data_o)
  );

  assign rx_en_o = ctrl.rx_en;
  assign rie_o   = ctrl.rie;
  assign mpie_o  = ctrl.mpie;
  assign rdf_o   = flags.rdf;
  assign fer_o   = flags.fer;
  assign ore_o   = flags.ore;
  assign rxi_o   = ctrl.rie & flags.rdf;
  assign eri_o   = ctrl.rie & (flags.fer | flags.ore);
endmodule

// File: tb/test_mpu_uart_rx.sv
module test_mpu_uart_rx;
  localparam int DIV = 4;
  localparam int BIT_CYC = 16 * DIV;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rxd = 1'b1, mp_mode = 1'b0;
  logic       cfg_wr = 1'b0, c_en = 1'b0, c_rie = 1'b0, c_mpie = 1'b0;
  logic [2:0] clr = 3'b000;
  logic       rx_en, rie, mpie, rdf, fer, ore, rxi, eri;
  logic [7:0] rdata;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  mpu_uart_rx #(.DATA_W(8), .OVS(16), .TICK_DIV(DIV)) i_mpu_uart_rx (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .mp_mode_i(mp_mode),
    .cfg_wr_i(cfg_wr), .cfg_rx_en_i(c_en), .cfg_rie_i(c_rie), .cfg_mpie_i(c_mpie),
    .flag_clr_i(clr), .rx_en_o(rx_en), .rie_o(rie), .mpie_o(mpie),
    .rx_data_o(rdata), .rdf_o(rdf), .fer_o(fer), .ore_o(ore),
    .rxi_o(rxi), .eri_o(eri)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic en, logic ie, logic mp);
    @(negedge clk);
    c_en = en; c_rie = ie; c_mpie = mp; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 3'b111;
    @(negedge clk); clr = 3'b000;
  endtask

  task automatic send(logic [7:0] d, logic has_mp, logic mpb, logic stop);
    @(negedge clk);
    rxd = 1'b0; cyc(BIT_CYC);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; cyc(BIT_CYC); end
    if (has_mp) begin rxd = mpb; cyc(BIT_CYC); end
    rxd = stop; cyc(BIT_CYC);
    rxd = 1'b1; cyc(24);
  endtask

  task automatic t_reset();
    check("R9 reset rdf", rdf, 0);
    check("R9 reset fer", fer, 0);
    check("R9 reset ore", ore, 0);
    check("R9 reset ctrl", {rx_en, rie, mpie}, 0);
    check("R8 reset irqs", {rxi, eri}, 0);
  endtask

  task automatic t_disabled();
    mp_mode = 1'b0;
    send(8'h3C, 1'b0, 1'b0, 1'b1);
    check("R2 disabled no rdf", rdf, 0);
    cfg(1'b1, 1'b0, 1'b0);
    @(negedge clk); rxd = 1'b0; cyc(3 * BIT_CYC);
    cfg(1'b0, 1'b0, 1'b0);
    rxd = 1'b1; cyc(12 * BIT_CYC);
    check("R2 abort no flags", {rdf, fer, ore}, 0);
  endtask

  task automatic t_normal();
    cfg(1'b1, 1'b0, 1'b0);
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R1 data", rdata, 8'hA5);
    check("R1 rdf", rdf, 1);
    check("R8 rxi gated off", rxi, 0);
    cfg(1'b1, 1'b1, 1'b0);
    check("R9 cfg readback", {rx_en, rie, mpie}, 3'b110);
    check("R8 rxi on", rxi, 1);
  endtask

  task automatic t_overrun();
    send(8'h11, 1'b0, 1'b0, 1'b1);
    check("R4 ore", ore, 1);
    check("R4 data kept", rdata, 8'hA5);
    check("R8 eri", eri, 1);
    clear_all();
    check("R9 clear", {rdf, fer, ore}, 0);
  endtask

  task automatic t_framing();
    send(8'h77, 1'b0, 1'b0, 1'b0);
    check("R3 fer", fer, 1);
    check("R3 rdf stays 0", rdf, 0);
    check("R8 eri fer", eri, 1);
    clear_all();
  endtask

  task automatic t_filter();
    mp_mode = 1'b1;
    cfg(1'b1, 1'b1, 1'b0);
    send(8'h42, 1'b1, 1'b0, 1'b1);
    check("R1 mp frame data", rdata, 8'h42);
    check("R1 mp frame rdf", rdf, 1);
    cfg(1'b1, 1'b1, 1'b1);
    send(8'h99, 1'b1, 1'b0, 1'b1);
    check("R5 no ore", ore, 0);
    check("R5 data kept", rdata, 8'h42);
    clear_all();
    send(8'h98, 1'b1, 1'b0, 1'b0);
    check("R5 no rdf/fer", {rdf, fer}, 0);
    check("R5 filter stays", mpie, 1);
  endtask

  task automatic t_wake();
    send(8'hC3, 1'b1, 1'b1, 1'b1);
    check("R6 filter cleared", mpie, 0);
    check("R6 wake data", rdata, 8'hC3);
    check("R6 wake rdf", rdf, 1);
    clear_all();
    send(8'h24, 1'b1, 1'b0, 1'b1);
    check("R6 later frame data", rdata, 8'h24);
    check("R6 later frame rdf", rdf, 1);
    clear_all();
  endtask

  task automatic t_mode_off();
    mp_mode = 1'b0;
    cfg(1'b1, 1'b1, 1'b1);
    send(8'h81, 1'b0, 1'b0, 1'b1);
    check("R7 data", rdata, 8'h81);
    check("R7 rdf", rdf, 1);
    check("R7 filter bit kept", mpie, 1);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_disabled();
    t_normal();
    t_overrun();
    t_framing();
    t_filter();
    t_wake();
    t_mode_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule